// File: doc/BRIEF.md
# Branch-Delay Next-PC Resolver

This block works out where execution continues after a branch or jump whose delay slot has already been dealt with. It takes the address of the control-transfer instruction and its 32-bit encoding. It also takes the two source-register values the instruction names and the floating-point condition/status word. From these it produces the resume address and, for linking forms, the register index and value to write back. Register reads, instruction fetch and execution of the delay-slot instruction happen outside the block.

A request is presented for one cycle with `req_valid` high. The response appears on the registered outputs on the next clock edge, together with `rsp_valid`. Two cases are flagged apart from a normal resolution. An instruction address that is not word aligned raises a fault. An encoding that is not a recognised control transfer raises a hold flag. In both cases the resume address equals the request address and no link write happens.

Top module: `bdr_resolver`

## Requirements
- R1: When `req_pc[1:0]` is nonzero, the response sets `rsp_misalign`, returns `rsp_next_pc` equal to `req_pc`, keeps `rsp_link_we` low and keeps `rsp_no_update` low, whatever the instruction.
- R2: A conditional branch that is taken resumes at `req_pc + 4 + (sign-extended insn[15:0] << 2)`. One that is not taken resumes at `req_pc + 8`.
- R3: Every linking form writes `req_pc + 8` as link data, whether or not its branch is taken.
- R4: With opcode `insn[31:26]` = 0 and function `insn[5:0]` = 0x08, the resume address is the rs value. Function 0x09 does the same and also links to register `insn[15:11]`.
- R5: With opcode 1, `insn[20:16]` selects the operation. 0x00 and 0x02 branch when rs < 0. 0x01 and 0x03 branch when rs >= 0. 0x10 and 0x12 do the same as 0x00 and link r31. 0x11 and 0x13 do the same as 0x01 and link r31. All comparisons are two's-complement.
- R6: Opcodes 2 and 3 resume at `{(req_pc+4)[31:28], insn[25:0], 2'b00}`. Opcode 3 also links r31.
- R7: Opcode 4 branches when rs equals rt and opcode 5 when they differ. Opcode 6 branches when rs <= 0 and opcode 7 when rs > 0, both signed, and both ignore the rt field and the rt value.
- R8: Opcodes 0x14, 0x15, 0x16 and 0x17 behave exactly like 4, 5, 6 and 7.
- R9: Opcode 0x11 acts only when `insn[20:16]` is 0 to 3. With cc = `insn[20:18]`, the condition bit is `fcsr[23]` for cc = 0 and `fcsr[24+cc]` otherwise. The branch is taken when that bit equals `insn[16]`.
- R10: Any other opcode, any other function code under opcode 0, any other rt code under opcode 1, and rt > 3 under opcode 0x11 set `rsp_no_update`, return `req_pc` and write no link.
- R11: A link write whose target index is 0 is suppressed (`rsp_link_we` stays low).
- R12: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `rst_n` is low at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_pc | input | 32 | Address of the control-transfer instruction |
| req_insn | input | 32 | Instruction encoding |
| req_rs_val | input | 32 | Value of the register named in insn[25:21] |
| req_rt_val | input | 32 | Value of the register named in insn[20:16] |
| req_fcsr | input | 32 | Floating-point condition/status word |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_next_pc | output | 32 | Resume address |
| rsp_link_we | output | 1 | Link write enable |
| rsp_link_idx | output | 5 | Link destination register |
| rsp_link_data | output | 32 | Link value |
| rsp_misalign | output | 1 | Unaligned instruction address fault |
| rsp_no_update | output | 1 | Encoding not a recognised control transfer |

## Verification
There is one register stage and no state is carried between requests, so any wrong decode or arithmetic appears in the response right after the request. It shows as a wrong `rsp_next_pc`, a wrong link field or a wrong flag, with no delay to hide it. A response register that fails to load or clear shows as `rsp_valid` out of step with requests in that same cycle, or as nonzero outputs while reset is held. The scoreboard therefore compares every response field against an independent model. This is done for each opcode group, for both branch outcomes and both signs of operand, and for region crossings on jumps and the r0 link target.

// File: rtl/bdr_pkg.sv
// Shared encodings and decode descriptor for the next-PC resolver.
// Assumes the classic 32-bit three-format encoding: opcode in [31:26].
package bdr_pkg;
    localparam logic [5:0] OP_SPECIAL = 6'h00;
    localparam logic [5:0] OP_REGIMM  = 6'h01;
    localparam logic [5:0] OP_J       = 6'h02;
    localparam logic [5:0] OP_JAL     = 6'h03;
    localparam logic [5:0] OP_BEQ     = 6'h04;
    localparam logic [5:0] OP_BNE     = 6'h05;
    localparam logic [5:0] OP_BLEZ    = 6'h06;
    localparam logic [5:0] OP_BGTZ    = 6'h07;
    localparam logic [5:0] OP_COP1    = 6'h11;
    localparam logic [5:0] OP_BEQL    = 6'h14;
    localparam logic [5:0] OP_BNEL    = 6'h15;
    localparam logic [5:0] OP_BLEZL   = 6'h16;
    localparam logic [5:0] OP_BGTZL   = 6'h17;

    localparam logic [5:0] FN_JR      = 6'h08;
    localparam logic [5:0] FN_JALR    = 6'h09;

    // Where the resume address comes from.
    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_REG,
        TGT_JUMP,
        TGT_BRANCH
    } tgt_e;

    // Which condition a conditional branch evaluates.
    typedef enum logic [2:0] {
        CND_EQ,
        CND_NE,
        CND_LEZ,
        CND_GTZ,
        CND_LTZ,
        CND_GEZ,
        CND_FCLR,
        CND_FSET
    } cnd_e;

    typedef struct packed {
        tgt_e       tgt;
        cnd_e       cnd;
        logic       link;
        logic [4:0] link_idx;
    } dec_t;
endpackage

// File: rtl/bdr_decode.sv
// Classifies an instruction into a compact descriptor: resume-address
// source, branch condition and link destination. Likely forms map onto
// the same descriptor as their plain forms. Link targets of r0 are
// dropped here. Assumes only opcode, rt, rd and function fields matter.
module bdr_decode
    import bdr_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic [5:0] op_i,
    input  logic [4:0] rt_i,
    input  logic [4:0] rd_i,
    input  logic [5:0] fn_i,
    output dec_t       dec_o
);
    localparam logic [4:0] LINK_IDX = 5'(LINK_REG);

    dec_t d;

    // Opcode/field lookup into the descriptor.
    always_comb begin
        d = '{tgt: TGT_NONE, cnd: CND_EQ, link: 1'b0, link_idx: 5'd0};
        case (op_i)
            OP_SPECIAL: begin
                if (fn_i == FN_JR) begin
                    d.tgt = TGT_REG;
                end else if (fn_i == FN_JALR) begin
                    d.tgt      = TGT_REG;
                    d.link     = 1'b1;
                    d.link_idx = rd_i;
                end
            end
            OP_REGIMM: begin
                case (rt_i)
                    5'h00, 5'h02: begin d.tgt = TGT_BRANCH; d.cnd = CND_LTZ; end
                    5'h01, 5'h03: begin d.tgt = TGT_BRANCH; d.cnd = CND_GEZ; end
                    5'h10, 5'h12: begin
                        d.tgt = TGT_BRANCH; d.cnd = CND_LTZ;
                        d.link = 1'b1; d.link_idx = LINK_IDX;
                    end
                    5'h11, 5'h13: begin
                        d.tgt = TGT_BRANCH; d.cnd = CND_GEZ;
                        d.link = 1'b1; d.link_idx = LINK_IDX;
                    end
                    default: ;
                endcase
            end
            OP_J:   d.tgt = TGT_JUMP;
            OP_JAL: begin
                d.tgt = TGT_JUMP; d.link = 1'b1; d.link_idx = LINK_IDX;
            end
            OP_BEQ,  OP_BEQL:  begin d.tgt = TGT_BRANCH; d.cnd = CND_EQ;  end
            OP_BNE,  OP_BNEL:  begin d.tgt = TGT_BRANCH; d.cnd = CND_NE;  end
            OP_BLEZ, OP_BLEZL: begin d.tgt = TGT_BRANCH; d.cnd = CND_LEZ; end
            OP_BGTZ, OP_BGTZL: begin d.tgt = TGT_BRANCH; d.cnd = CND_GTZ; end
            OP_COP1: begin
                if (rt_i < 5'd4) begin
                    d.tgt = TGT_BRANCH;
                    d.cnd = rt_i[0] ? CND_FSET : CND_FCLR;
                end
            end
            default: ;
        endcase
    end

    // Drop writes aimed at the hard-wired zero register.
    always_comb begin
        dec_o = d;
        if (d.link_idx == 5'd0) dec_o.link = 1'b0;
    end
endmodule

// File: rtl/bdr_cond.sv
// Evaluates the branch condition named by the descriptor. Integer
// comparisons are two's-complement. The floating-point condition bit sits
// at FCC_BASE for cc 0 and at FCC_BASE+1+cc above that.
module bdr_cond
    import bdr_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int FCSR_W   = 32,
    parameter int FCC_BASE = 23
) (
    input  cnd_e              cnd_i,
    input  logic [XLEN-1:0]   rs_val_i,
    input  logic [XLEN-1:0]   rt_val_i,
    input  logic [FCSR_W-1:0] fcsr_i,
    input  logic [2:0]        cc_i,
    output logic              taken_o
);
    localparam int IDX_W = $clog2(FCSR_W);

    logic [IDX_W-1:0] bit_idx;
    logic             fbit;
    logic             rs_neg;
    logic             rs_zero;

    // Irregular condition-bit position: a gap follows the first bit.
    always_comb begin
        if (cc_i == 3'd0) bit_idx = IDX_W'(FCC_BASE);
        else              bit_idx = IDX_W'(FCC_BASE + 1) + IDX_W'(cc_i);
    end

    assign fbit    = fcsr_i[bit_idx];
    assign rs_neg  = rs_val_i[XLEN-1];
    assign rs_zero = (rs_val_i == '0);

    // Condition select.
    always_comb begin
        case (cnd_i)
            CND_EQ:   taken_o = (rs_val_i == rt_val_i);
            CND_NE:   taken_o = (rs_val_i != rt_val_i);
            CND_LEZ:  taken_o = rs_neg || rs_zero;
            CND_GTZ:  taken_o = !rs_neg && !rs_zero;
            CND_LTZ:  taken_o = rs_neg;
            CND_GEZ:  taken_o = !rs_neg;
            CND_FCLR: taken_o = !fbit;
            CND_FSET: taken_o = fbit;
            default:  taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bdr_target.sv
// Computes the three candidate resume addresses in parallel: fall-through
// past the delay slot, PC-relative branch target, and region jump target.
// Assumes 4-byte instructions and a 28-bit jump region.
module bdr_target #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [15:0]     imm_i,
    input  logic [25:0]     tgt_i,
    output logic [XLEN-1:0] seq_o,
    output logic [XLEN-1:0] br_o,
    output logic [XLEN-1:0] jmp_o
);
    localparam int RGN_W = XLEN - 28;

    logic [XLEN-1:0] pc4;
    logic [XLEN-1:0] offset;

    assign pc4    = pc_i + XLEN'(4);
    assign offset = {{(XLEN-18){imm_i[15]}}, imm_i, 2'b00};
    assign seq_o  = pc_i + XLEN'(8);
    assign br_o   = pc4 + offset;
    // Region bits come from the delay-slot address, not the branch address.
    assign jmp_o  = {pc4[XLEN-1 -: RGN_W], tgt_i, 2'b00};
endmodule

// File: rtl/bdr_resolver.sv
// Top of the next-PC resolver. Decodes the instruction, evaluates the
// condition, picks the resume address and registers the response one
// cycle after the request. Unaligned addresses override every result.
// Assumes the caller supplies rs/rt values already read for this insn.
module bdr_resolver
    import bdr_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int FCSR_W   = 32,
    parameter int FCC_BASE = 23,
    parameter int LINK_REG = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [XLEN-1:0]   req_pc,
    input  logic [31:0]       req_insn,
    input  logic [XLEN-1:0]   req_rs_val,
    input  logic [XLEN-1:0]   req_rt_val,
    input  logic [FCSR_W-1:0] req_fcsr,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_next_pc,
    output logic              rsp_link_we,
    output logic [4:0]        rsp_link_idx,
    output logic [XLEN-1:0]   rsp_link_data,
    output logic              rsp_misalign,
    output logic              rsp_no_update
);
    dec_t            dec;
    logic            taken;
    logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;
    logic            misalign;
    logic [XLEN-1:0] nxt_pc;
    logic            nxt_we;
    logic            nxt_hold;

    bdr_decode #(.LINK_REG(LINK_REG)) u_dec (
        .op_i  (req_insn[31:26]),
        .rt_i  (req_insn[20:16]),
        .rd_i  (req_insn[15:11]),
        .fn_i  (req_insn[5:0]),
        .dec_o (dec)
    );

    bdr_cond #(.XLEN(XLEN), .FCSR_W(FCSR_W), .FCC_BASE(FCC_BASE)) u_cond (
        .cnd_i    (dec.cnd),
        .rs_val_i (req_rs_val),
        .rt_val_i (req_rt_val),
        .fcsr_i   (req_fcsr),
        .cc_i     (req_insn[20:18]),
        .taken_o  (taken)
    );

    bdr_target #(.XLEN(XLEN)) u_tgt (
        .pc_i  (req_pc),
        .imm_i (req_insn[15:0]),
        .tgt_i (req_insn[25:0]),
        .seq_o (seq_pc),
        .br_o  (br_pc),
        .jmp_o (jmp_pc)
    );

    assign misalign = |req_pc[1:0];

    // Resume-address select; fault and unknown encodings hold the PC.
    always_comb begin
        nxt_hold = 1'b0;
        case (dec.tgt)
            TGT_REG:    nxt_pc = req_rs_val;
            TGT_JUMP:   nxt_pc = jmp_pc;
            TGT_BRANCH: nxt_pc = taken ? br_pc : seq_pc;
            default: begin
                nxt_pc   = req_pc;
                nxt_hold = 1'b1;
            end
        endcase
        nxt_we = dec.link;
        if (misalign) begin
            nxt_pc   = req_pc;
            nxt_hold = 1'b0;
            nxt_we   = 1'b0;
        end
    end

    // Response register: loads on a request, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_next_pc   <= '0;
            rsp_link_we   <= 1'b0;
            rsp_link_idx  <= '0;
            rsp_link_data <= '0;
            rsp_misalign  <= 1'b0;
            rsp_no_update <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_next_pc   <= nxt_pc;
                rsp_link_we   <= nxt_we;
                rsp_link_idx  <= nxt_we ? dec.link_idx : 5'd0;
                rsp_link_data <= nxt_we ? seq_pc : '0;
                rsp_misalign  <= misalign;
                rsp_no_update <= nxt_hold;
            end
        end
    end

    assert_fault_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_misalign |->
            !rsp_link_we && !rsp_no_update && rsp_next_pc == $past(req_pc));

    assert_link_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_link_we |-> rsp_link_data == $past(req_pc) + XLEN'(8));

    assert_hold_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_no_update |->
            !rsp_link_we && !rsp_misalign && rsp_next_pc == $past(req_pc));

    assert_no_r0_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_link_we |-> rsp_link_idx != 5'd0);

    assert_rsp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
endmodule

// File: tb/bdr_resolver_tb_top.sv
// Scoreboard bench: the driver computes expected responses from the
// requirements and queues them; the monitor compares each response.
module bdr_resolver_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_pc, req_insn, req_rs_val, req_rt_val, req_fcsr;
    logic        rsp_valid, rsp_link_we, rsp_misalign, rsp_no_update;
    logic [31:0] rsp_next_pc, rsp_link_data;
    logic [4:0]  rsp_link_idx;

    typedef struct packed {
        logic [31:0] npc;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] data;
        logic        mis;
        logic        hold;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    total = 0;
    int    bad   = 0;
    bit    run   = 1'b0;

    always #10 clk = ~clk;

    bdr_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pc(req_pc),
        .req_insn(req_insn), .req_rs_val(req_rs_val), .req_rt_val(req_rt_val),
        .req_fcsr(req_fcsr), .rsp_valid(rsp_valid), .rsp_next_pc(rsp_next_pc),
        .rsp_link_we(rsp_link_we), .rsp_link_idx(rsp_link_idx),
        .rsp_link_data(rsp_link_data), .rsp_misalign(rsp_misalign),
        .rsp_no_update(rsp_no_update)
    );

    function automatic logic [31:0] ei(int op, int rsf, int rtf, int imm);
        ei = {op[5:0], rsf[4:0], rtf[4:0], imm[15:0]};
    endfunction

    function automatic logic [31:0] er(int rsf, int rtf, int rd, int fn);
        er = {6'd0, rsf[4:0], rtf[4:0], rd[4:0], 5'd0, fn[5:0]};
    endfunction

    function automatic logic [31:0] ej(int op, int tgt);
        ej = {op[5:0], tgt[25:0]};
    endfunction

    // Expected response, written from the requirement text.
    function automatic exp_t model(logic [31:0] pc, logic [31:0] insn,
                                   logic [31:0] rs, logic [31:0] rt,
                                   logic [31:0] fcsr);
        exp_t e;
        int op, rtf, fn, ccv, bi, lnk;
        bit br, tk;
        logic [31:0] seq, brt, p4;
        e = '{npc: pc, we: 1'b0, idx: 5'd0, data: 32'd0, mis: 1'b0, hold: 1'b0};
        if (pc[1:0] != 2'b00) begin e.mis = 1'b1; return e; end
        op = int'(insn[31:26]); rtf = int'(insn[20:16]); fn = int'(insn[5:0]);
        seq = pc + 32'd8; p4 = pc + 32'd4;
        brt = p4 + {{14{insn[15]}}, insn[15:0], 2'b00};
        br = 1'b0; tk = 1'b0; lnk = 0;
        case (op)
            0: if (fn == 8) e.npc = rs;
               else if (fn == 9) begin e.npc = rs; lnk = int'(insn[15:11]); end
               else e.hold = 1'b1;
            1: case (rtf)
                   0, 2:   begin br = 1; tk = $signed(rs) < 0; end
                   1, 3:   begin br = 1; tk = $signed(rs) >= 0; end
                   16, 18: begin br = 1; tk = $signed(rs) < 0; lnk = 31; end
                   17, 19: begin br = 1; tk = $signed(rs) >= 0; lnk = 31; end
                   default: e.hold = 1'b1;
               endcase
            2: e.npc = {p4[31:28], insn[25:0], 2'b00};
            3: begin e.npc = {p4[31:28], insn[25:0], 2'b00}; lnk = 31; end
            4, 20: begin br = 1; tk = (rs == rt); end
            5, 21: begin br = 1; tk = (rs != rt); end
            6, 22: begin br = 1; tk = $signed(rs) <= 0; end
            7, 23: begin br = 1; tk = $signed(rs) > 0; end
            17: if (rtf < 4) begin
                    ccv = rtf >> 2;
                    bi = (ccv == 0) ? 23 : 24 + ccv;
                    br = 1; tk = (fcsr[bi] == insn[16]);
                end else e.hold = 1'b1;
            default: e.hold = 1'b1;
        endcase
        if (br) e.npc = tk ? brt : seq;
        if (lnk != 0) begin e.we = 1'b1; e.idx = 5'(lnk); e.data = seq; end
        return e;
    endfunction

    task automatic send(logic [31:0] pc, logic [31:0] insn, logic [31:0] rs,
                        logic [31:0] rt, logic [31:0] fcsr, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_insn = insn;
        req_rs_val = rs; req_rt_val = rt; req_fcsr = fcsr;
        exp_q.push_back(model(pc, insn, rs, rt, fcsr));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_insn  = 32'hFFFF_FFFF;
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Monitor: samples mid-cycle after each rising edge and pops the queue.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (run) begin
                if (exp_q.size() > 0) begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    total++;
                    if (!rsp_valid || rsp_next_pc !== e.npc || rsp_link_we !== e.we ||
                        rsp_misalign !== e.mis || rsp_no_update !== e.hold ||
                        (e.we && (rsp_link_idx !== e.idx || rsp_link_data !== e.data))) begin
                        bad++;
                        $display("FAIL %s: actual v=%b pc=%h we=%b idx=%0d data=%h mis=%b hold=%b expected v=1 pc=%h we=%b idx=%0d data=%h mis=%b hold=%b",
                                 t, rsp_valid, rsp_next_pc, rsp_link_we, rsp_link_idx,
                                 rsp_link_data, rsp_misalign, rsp_no_update,
                                 e.npc, e.we, e.idx, e.data, e.mis, e.hold);
                    end
                end else begin
                    total++;
                    if (rsp_valid !== 1'b0) begin
                        bad++;
                        $display("FAIL R12: actual rsp_valid=%b expected 0 on idle cycle", rsp_valid);
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    // Driver: reset, directed corners, then random traffic.
    initial begin
        rst_n = 1'b0; req_valid = 1'b1; req_pc = 32'h1000; req_insn = ej(3, 5);
        req_rs_val = 0; req_rt_val = 0; req_fcsr = 0;
        repeat (3) @(posedge clk);
        #5;
        total++;
        if ({rsp_valid, rsp_next_pc, rsp_link_we, rsp_link_idx, rsp_link_data,
             rsp_misalign, rsp_no_update} !== '0) begin
            bad++;
            $display("FAIL R12: actual v=%b pc=%h we=%b expected all zero in reset",
                     rsp_valid, rsp_next_pc, rsp_link_we);
        end
        @(negedge clk);
        req_valid = 1'b0;
        rst_n = 1'b1;
        run = 1'b1;
        idle(2);

        // R1: unaligned addresses fault regardless of the instruction
        send(32'h0000_1002, ei(4, 1, 2, 3), 5, 5, 0, "R1");
        send(32'h0000_1001, ej(3, 32'h40), 0, 0, 0, "R1");
        send(32'h0000_1003, er(1, 0, 31, 9), 32'h2000, 0, 0, "R1");
        // R2/R7: equality branches, forward and backward offsets
        send(32'h0000_1000, ei(4, 1, 2, 3), 7, 7, 0, "R2 R7");
        send(32'h0000_1000, ei(4, 1, 2, 3), 7, 8, 0, "R2 R7");
        send(32'h0000_1000, ei(5, 1, 2, 16'hFFFC), 7, 8, 0, "R2 R7");
        send(32'h0000_1000, ei(5, 1, 2, 16'hFFFC), 9, 9, 0, "R7");
        // R7: signed zero compares ignoring rt
        send(32'h0000_2000, ei(6, 1, 9, 8), 0, 1, 0, "R7");
        send(32'h0000_2000, ei(6, 1, 9, 8), 32'hFFFF_FFFF, 0, 0, "R7");
        send(32'h0000_2000, ei(6, 1, 9, 8), 32'h0000_0001, 5, 0, "R7");
        send(32'h0000_2000, ei(7, 1, 0, 8), 32'h8000_0000, 0, 0, "R7");
        send(32'h0000_2000, ei(7, 1, 0, 8), 32'h7FFF_FFFF, 0, 0, "R7");
        // R8: likely forms
        send(32'h0000_3000, ei(20, 1, 2, 5), 3, 3, 0, "R8");
        send(32'h0000_3000, ei(21, 1, 2, 5), 3, 3, 0, "R8");
        send(32'h0000_3000, ei(22, 1, 0, 5), 0, 0, 0, "R8");
        send(32'h0000_3000, ei(23, 1, 0, 5), 0, 0, 0, "R8");
        // R5/R3: regimm group, linking forms link even when not taken
        send(32'h0000_4000, ei(1, 1, 0, 2), 32'hFFFF_FFF0, 0, 0, "R5");
        send(32'h0000_4000, ei(1, 1, 2, 2), 0, 0, 0, "R5");
        send(32'h0000_4000, ei(1, 1, 1, 2), 0, 0, 0, "R5");
        send(32'h0000_4000, ei(1, 1, 3, 2), 32'h8000_0000, 0, 0, "R5");
        send(32'h0000_4000, ei(1, 1, 16, 2), 5, 0, 0, "R3 R5");
        send(32'h0000_4000, ei(1, 1, 18, 2), 32'hFFFF_FFFF, 0, 0, "R3 R5");
        send(32'h0000_4000, ei(1, 1, 17, 2), 32'hFFFF_FFFF, 0, 0, "R3 R5");
        send(32'h0000_4000, ei(1, 1, 19, 2), 0, 0, 0, "R3 R5");
        // R6: region jumps, including a region crossing at PC+4
        send(32'h3FFF_FFFC, ej(2, 26'h3FF_FFFF), 0, 0, 0, "R6");
        send(32'h1234_5678, ej(3, 26'h000_0010), 0, 0, 0, "R6 R3");
        // R4/R11: register jumps and r0 suppression
        send(32'h0000_5000, er(4, 0, 0, 8), 32'hDEAD_BEE0, 0, 0, "R4");
        send(32'h0000_5000, er(4, 0, 5, 9), 32'h0000_8000, 0, 0, "R4 R3");
        send(32'h0000_5000, er(4, 0, 0, 9), 32'h0000_8000, 0, 0, "R11");
        // R9: coprocessor condition branches on bit 23
        send(32'h0000_6000, ei(17, 8, 0, 4), 0, 0, 32'h0000_0000, "R9");
        send(32'h0000_6000, ei(17, 8, 0, 4), 0, 0, 32'h0080_0000, "R9");
        send(32'h0000_6000, ei(17, 8, 1, 4), 0, 0, 32'h0080_0000, "R9");
        send(32'h0000_6000, ei(17, 8, 3, 4), 0, 0, 32'hFF7F_FFFF, "R9");
        send(32'h0000_6000, ei(17, 8, 2, 4), 0, 0, 32'hFF7F_FFFF, "R9");
        // R10: unrecognised encodings hold the PC
        send(32'h0000_7000, ei(17, 8, 4, 4), 0, 0, 32'h0080_0000, "R10");
        send(32'h0000_7000, er(1, 2, 31, 12), 0, 0, 0, "R10");
        send(32'h0000_7000, ei(1, 1, 5, 4), 0, 0, 0, "R10");
        send(32'h0000_7000, ei(8, 1, 31, 4), 0, 0, 0, "R10");
        idle(3);

        // Random mix with gaps (R2 R5 R9 R12 among others).
        for (int n = 0; n < 400; n++) begin
            int ops[14] = '{0, 1, 2, 3, 4, 5, 6, 7, 17, 20, 21, 22, 23, 9};
            int rimm[9] = '{0, 1, 2, 3, 16, 17, 18, 19, 6};
            int fns[3]  = '{8, 9, 12};
            int op;
            logic [31:0] ins, pc;
            op  = ops[$urandom_range(0, 13)];
            ins = $urandom;
            ins[31:26] = 6'(op);
            if (op == 0) ins[5:0] = 6'(fns[$urandom_range(0, 2)]);
            if (op == 1) ins[20:16] = 5'(rimm[$urandom_range(0, 8)]);
            if (op == 17) ins[20:16] = 5'($urandom_range(0, 7));
            pc = $urandom;
            if ($urandom_range(0, 7) != 0) pc[1:0] = 2'b00;
            send(pc, ins, $urandom_range(0, 3) == 0 ? 32'd0 : 32'($urandom),
                 $urandom_range(0, 1) == 0 ? 32'($urandom) : 32'd5, 32'($urandom),
                 "R2 random");
            if ($urandom_range(0, 3) == 0) idle(1);
        end
        idle(4);
        total++;
        if (exp_q.size() != 0) begin
            bad++;
            $display("FAIL R12: actual %0d responses missing expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule